// File: doc/BRIEF.md
# Set-Clear-Status Clock Gate Bank

This block keeps one clock-enable bit and one reset bit for each of up to 32 peripherals and drives them out as level signals towards the clock gating cells and reset synchronizers that sit outside it. Software reaches each of the two control words through three word addresses: one where written ones switch bits on, one where written ones switch bits off, and one that reads back the current word. Bits written as zero keep their value, so several drivers can control separate peripherals without a read-modify-write sequence.

The block sits on a simple synchronous register bus with an address, a write strobe with write data, and a read strobe. Read data is returned on the cycle after the read strobe. After reset every clock is off and every peripheral is held in reset. To start a peripheral, software first clears its reset bit and then sets its enable bit.

Top module: `scs_gate_bank`

## Requirements
- R1: After reset the enable word is all zeros, the reset word is all ones and `rd_data` is zero.
- R2: A write to a group's set address (group base + 0x0; enable base 0x00, reset base 0x10) turns on exactly the bits that are one in `wr_data`. All other bits keep their value.
- R3: A write to a group's clear address (group base + 0x4) turns off exactly the bits that are one in `wr_data`. All other bits keep their value.
- R4: A read strobe on a group's status address (group base + 0x8) returns that group's current word on `rd_data` in the next cycle. The value includes every write accepted on an earlier cycle. `rd_data` is zero in any cycle that does not follow a read strobe.
- R5: Reading a set address or a clear address returns zero.
- R6: A write to a status address changes neither word.
- R7: Any other address is unmapped. This covers offset 0xC in either group, any address with bits [1:0] not zero, and any address outside both groups. A write to an unmapped address changes nothing, and a read of one returns zero.
- R8: `clk_en_o` and `periph_rst_o` take their new value on the clock edge that accepts the write. They stay unchanged on edges that accept no write.
- R9: Clearing a peripheral's reset bit and then setting its enable bit leaves that peripheral out of reset with its clock on. Every other peripheral keeps its previous state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data; ones select the bits that are acted on |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| clk_en_o | output | 32 | Clock-enable level per peripheral |
| periph_rst_o | output | 32 | Reset level per peripheral, high holds the peripheral in reset |

## Verification
The assertions assume one bus operation per cycle: the write strobe and the read strobe are never high in the same cycle. They also assume both group bases are 16-byte aligned and distinct. The stimulus keeps to this rule. Each random operation is either a single write or a single read, with the strobe high for exactly one cycle and driven away from the clock edge. Addresses are drawn from both groups' mapped offsets, from offset 0xC, from misaligned addresses and from addresses outside both groups.

// File: rtl/scs_pkg.sv
// Package: shared types for the set/clear/status gate bank.
// Assumes: each group spans four word slots inside a 16-byte window.
package scs_pkg;

    // Word slot of an access inside its group window (byte offset / 4).
    localparam logic [1:0] SLOT_SET    = 2'd0;
    localparam logic [1:0] SLOT_CLEAR  = 2'd1;
    localparam logic [1:0] SLOT_STATUS = 2'd2;

    // Number of controlled words (clock enable and peripheral reset).
    localparam int NUM_GROUPS = 2;
    localparam int GRP_ENABLE = 0;
    localparam int GRP_RESET  = 1;

    // Per-group decoded selects; at most one select of all groups is high.
    typedef struct packed {
        logic set_sel;
        logic clr_sel;
        logic sts_sel;
    } scs_grp_sel_t;

endpackage

// File: rtl/scs_addr_decode.sv
// Module: scs_addr_decode
// Turns a byte address into set/clear/status selects for the enable and the
// reset groups.
// Assumes: bases are 16-byte aligned and distinct; misaligned or slot-3
// addresses select nothing.
module scs_addr_decode
    import scs_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] EN_BASE  = 8'h00,
    parameter logic [ADDR_W-1:0] RST_BASE = 8'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    output scs_grp_sel_t [NUM_GROUPS-1:0] sel
);
    localparam int WIN_LSB = 4;

    logic [NUM_GROUPS-1:0][ADDR_W-1:0] bases;
    assign bases[GRP_ENABLE] = EN_BASE;
    assign bases[GRP_RESET]  = RST_BASE;

    logic       aligned;
    logic [1:0] slot;
    assign aligned = (addr[1:0] == 2'b00);
    assign slot    = addr[3:2];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit;
        // Purpose: match the address window of this group.
        always_comb begin
            hit = aligned && (addr[ADDR_W-1:WIN_LSB] == bases[g][ADDR_W-1:WIN_LSB]);
        end
        // Purpose: pick the slot inside the matched window.
        always_comb begin
            sel[g].set_sel = hit && (slot == SLOT_SET);
            sel[g].clr_sel = hit && (slot == SLOT_CLEAR);
            sel[g].sts_sel = hit && (slot == SLOT_STATUS);
        end
    end

    // R7: no address selects more than one slot anywhere.
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel[GRP_ENABLE], sel[GRP_RESET]}));

    // R7: a misaligned address selects nothing.
    p_misaligned_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> ({sel[GRP_ENABLE], sel[GRP_RESET]} == '0));

endmodule

// File: rtl/scs_sc_word.sv
// Module: scs_sc_word
// One control word with write-one-to-set and write-one-to-clear strobes.
// Assumes: set and clear strobes are never high in the same cycle.
module scs_sc_word #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Purpose: hold the word, or-in set bits and mask out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (set_stb) begin
            q <= q | wdata;
        end else if (clr_stb) begin
            q <= q & ~wdata;
        end
    end

    // R1: the word starts from its reset value.
    p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (q == RESET_VAL));

    // R2: every written one is on after a set.
    p_set_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & $past(wdata)) == $past(wdata)));

    // R2: a set leaves bits written as zero alone.
    p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    // R3: every written one is off after a clear.
    p_clear_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((q & $past(wdata)) == '0));

    // R3: a clear leaves bits written as zero alone.
    p_clear_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    // R8: without a strobe the word holds.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q));

endmodule

// File: rtl/scs_rd_mux.sv
// Module: scs_rd_mux
// Registered read path: returns a status word one cycle after the strobe,
// zero otherwise.
// Assumes: sel is one-hot or zero; W <= DATA_W.
module scs_rd_mux
    import scs_pkg::*;
#(
    parameter int W      = 32,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  scs_grp_sel_t [NUM_GROUPS-1:0] sel,
    input  logic [W-1:0]                  en_word,
    input  logic [W-1:0]                  rst_word,
    output logic [DATA_W-1:0]             rd_data
);
    logic [DATA_W-1:0] rd_next;

    // Purpose: choose the status word addressed, zero-extended to the bus.
    always_comb begin
        rd_next = '0;
        if (sel[GRP_ENABLE].sts_sel) begin
            rd_next[W-1:0] = en_word;
        end else if (sel[GRP_RESET].sts_sel) begin
            rd_next[W-1:0] = rst_word;
        end
    end

    // Purpose: capture read data on a strobe, drive zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_next;
        end else begin
            rd_data <= '0;
        end
    end

    // R4: data appears only in the cycle after a read strobe.
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R5: reads of set and clear slots return zero.
    p_sc_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel[GRP_ENABLE].set_sel || sel[GRP_ENABLE].clr_sel ||
                   sel[GRP_RESET].set_sel  || sel[GRP_RESET].clr_sel))
        |=> (rd_data == '0));

    // R4: an enable status read returns the word seen at the strobe.
    p_en_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel[GRP_ENABLE].sts_sel) |=> (rd_data[W-1:0] == $past(en_word)));

endmodule

// File: rtl/scs_gate_bank.sv
// Module: scs_gate_bank (top)
// Bank of per-peripheral clock-enable and reset bits, each word reached
// through set, clear and status addresses on a simple register bus.
// Assumes: one bus operation per cycle (wr_en and rd_en never together);
// NUM_PERIPH <= DATA_W; bases 16-byte aligned and distinct.
module scs_gate_bank
    import scs_pkg::*;
#(
    parameter int                NUM_PERIPH = 32,
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] EN_BASE    = 8'h00,
    parameter logic [ADDR_W-1:0] RST_BASE   = 8'h10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rd_data,
    output logic [NUM_PERIPH-1:0] clk_en_o,
    output logic [NUM_PERIPH-1:0] periph_rst_o
);
    localparam logic [NUM_PERIPH-1:0] EN_RESET_VAL  = '0;
    localparam logic [NUM_PERIPH-1:0] RST_RESET_VAL = '1;

    scs_grp_sel_t [NUM_GROUPS-1:0] sel;
    logic [NUM_GROUPS-1:0][NUM_PERIPH-1:0] words;
    logic [NUM_PERIPH-1:0] wbits;

    assign wbits = wr_data[NUM_PERIPH-1:0];

    scs_addr_decode #(
        .ADDR_W  (ADDR_W),
        .EN_BASE (EN_BASE),
        .RST_BASE(RST_BASE)
    ) decode_i (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .sel  (sel)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_word
        localparam logic [NUM_PERIPH-1:0] RV =
            (g == GRP_RESET) ? RST_RESET_VAL : EN_RESET_VAL;
        scs_sc_word #(
            .W        (NUM_PERIPH),
            .RESET_VAL(RV)
        ) word_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_stb(wr_en && sel[g].set_sel),
            .clr_stb(wr_en && sel[g].clr_sel),
            .wdata  (wbits),
            .q      (words[g])
        );
    end

    scs_rd_mux #(
        .W     (NUM_PERIPH),
        .DATA_W(DATA_W)
    ) rdmux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .sel     (sel),
        .en_word (words[GRP_ENABLE]),
        .rst_word(words[GRP_RESET]),
        .rd_data (rd_data)
    );

    assign clk_en_o     = words[GRP_ENABLE];
    assign periph_rst_o = words[GRP_RESET];

    // Bus rule assumed by the checks: never read and write together.
    p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R6: a write to either status slot leaves both outputs alone.
    p_status_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel[GRP_ENABLE].sts_sel || sel[GRP_RESET].sts_sel))
        |=> ($stable(clk_en_o) && $stable(periph_rst_o)));

    // R7: a write that selects no slot leaves both outputs alone.
    p_unmapped_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ({sel[GRP_ENABLE], sel[GRP_RESET]} == '0))
        |=> ($stable(clk_en_o) && $stable(periph_rst_o)));

    // R8: a write to the enable group never moves the reset outputs.
    p_en_write_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel[GRP_ENABLE].set_sel || sel[GRP_ENABLE].clr_sel))
        |=> $stable(periph_rst_o));

endmodule

// File: tb/scs_gate_bank_tb.sv
`timescale 1ns/1ps
// Bench for scs_gate_bank: directed corner cases plus seeded random traffic
// checked against a bench-side model of the two words.
module scs_gate_bank_tb_top;
    localparam int N  = 32;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] ENB = 8'h00;
    localparam logic [AW-1:0] RSB = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  clk_en_o;
    logic [N-1:0]  periph_rst_o;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_en;
    logic [N-1:0] m_rst;

    always #2.5 clk = ~clk;

    scs_gate_bank #(.NUM_PERIPH(N), .ADDR_W(AW), .DATA_W(DW),
                    .EN_BASE(ENB), .RST_BASE(RSB)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .clk_en_o(clk_en_o), .periph_rst_o(periph_rst_o));

    function automatic void model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        if      (a == ENB)        m_en  = m_en  | d[N-1:0];
        else if (a == ENB + 8'h4) m_en  = m_en  & ~d[N-1:0];
        else if (a == RSB)        m_rst = m_rst | d[N-1:0];
        else if (a == RSB + 8'h4) m_rst = m_rst & ~d[N-1:0];
    endfunction

    function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
        if (a == ENB + 8'h8) return DW'(m_en);
        if (a == RSB + 8'h8) return DW'(m_rst);
        return '0;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check(req, DW'(clk_en_o), DW'(m_en));
        check(req, DW'(periph_rst_o), DW'(m_rst));
    endtask

    // Write is accepted at the next rising edge; outputs sampled at the following falling edge.
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    // Read strobe at one rising edge; data is sampled at the next falling edge.
    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] r;
        logic [N-1:0]  keep_en;
        int unsigned   seed;
        logic [AW-1:0] pool [12];
        seed = 32'd20240517;
        void'($urandom(seed));
        m_en = '0; m_rst = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", DW'(clk_en_o), '0);
        check("R1", DW'(periph_rst_o), '1);
        check("R1", rd_data, '0);

        // R2: set on enable word
        bus_write(ENB, 32'h0000_00F0);
        check_outs("R2");
        bus_write(ENB, 32'h8000_0003);
        check_outs("R2");
        // R3: clear on enable word keeps other bits
        bus_write(ENB + 8'h4, 32'h0000_0030);
        check_outs("R3");
        check("R3", DW'(clk_en_o), 32'h8000_00C3);
        // R4: status read-back and idle zero
        bus_read(ENB + 8'h8, r);
        check("R4", r, 32'h8000_00C3);
        @(negedge clk);
        check("R4", rd_data, '0);
        // R5: set and clear addresses read as zero
        bus_read(ENB, r);       check("R5", r, '0);
        bus_read(RSB + 8'h4, r); check("R5", r, '0);
        // R6: status writes ignored
        bus_write(ENB + 8'h8, 32'hFFFF_FFFF);
        check_outs("R6");
        bus_write(RSB + 8'h8, 32'h0000_0000);
        check_outs("R6");
        // R7: unmapped writes and reads
        bus_write(ENB + 8'hC, 32'hFFFF_FFFF); check_outs("R7");
        bus_write(ENB + 8'h1, 32'hFFFF_FFFF); check_outs("R7");
        bus_write(8'h24, 32'hFFFF_FFFF);      check_outs("R7");
        bus_write(RSB + 8'h6, 32'hFFFF_FFFF); check_outs("R7");
        bus_read(8'h28, r);       check("R7", r, '0);
        bus_read(RSB + 8'h9, r);  check("R7", r, '0);
        // R8: output changes right at the accepting edge, holds otherwise
        @(negedge clk);
        addr = RSB + 8'h4; wr_data = 32'h0000_0100; wr_en = 1'b1;
        @(posedge clk); #1;
        check("R8", DW'(periph_rst_o), DW'(m_rst & ~32'h0000_0100));
        @(negedge clk); wr_en = 1'b0; model_write(RSB + 8'h4, 32'h0000_0100);
        repeat (3) @(negedge clk);
        check_outs("R8");
        // R9: bring-up sequence for peripheral 5
        keep_en = m_en;
        bus_write(RSB + 8'h4, 32'h0000_0020);
        bus_write(ENB, 32'h0000_0020);
        check("R9", DW'(periph_rst_o[5]), '0);
        check("R9", DW'(clk_en_o[5]), 32'h1);
        check("R9", DW'(clk_en_o), DW'(keep_en | 32'h0000_0020));
        check_outs("R9");

        // Random traffic over mapped, slot-3, misaligned and outside addresses
        pool = '{ENB, ENB+8'h4, ENB+8'h8, ENB+8'hC, RSB, RSB+8'h4, RSB+8'h8,
                 RSB+8'hC, 8'h02, 8'h13, 8'h40, 8'hFC};
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = pool[$urandom_range(11)];
            if ($urandom_range(1) == 1) begin
                bus_write(a, $urandom());
                check_outs("R2 R3 R6 R7 random");
            end else begin
                bus_read(a, r);
                check("R4 R5 R7 random", r, model_read(a));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule